// File: doc/BRIEF.md
# Serial Register Configuration Master

This block programs the control registers of an external clock-distribution device over a three- or four-wire serial control port. On a start pulse it walks an internal constant table of register address and data pairs, writing each entry as its own single-byte transaction. Once the table is exhausted it writes the value 0x01 to a register-update address, which makes the device apply the new settings, and then signals completion. Every transaction consists of a 16-bit instruction word followed by one or more data bytes.

A host can also issue single transactions directly: a write of one to four bytes, or a readback of one to four bytes. In a readback, the master drives the instruction and then hands the shared data pin over to the device. Two per-transaction mode inputs select the wire mode and the bit order. In four-wire mode, returned data arrives on a separate input pin. In LSB-first mode, the bit order within every field is reversed.

The controller has five states. IDLE waits for a request. FETCH loads the next table entry, or the update write. XFER runs the serial clock and shifts bits. GAP holds chip select high between transactions. FINISH pulses done for one cycle. The transitions are:
- IDLE to FETCH on start.
- IDLE to XFER on a host request.
- FETCH to XFER always.
- XFER to GAP on the falling serial clock edge after the last bit.
- GAP to FETCH while table entries or the update write remain.
- GAP to FINISH otherwise.
- FINISH to IDLE always.

Top module: `spi_cfg_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, done is 0 and sdio_oe is 1.
- R2: sclk idles low whenever cs_n is high. While running, each sclk half period lasts CLK_DIV system clocks, so a full period is 2*CLK_DIV clocks.
- R3: The instruction word is 16 bits. Bit 15 is the direction (1 = read). Bits 14:13 are the length code (00 = 1 byte, 01 = 2, 10 = 3, 11 = streaming of 4 bytes). Bits 12:0 are the register address. In MSB-first mode, bit 15 is sent first.
- R4: sdio_o changes only on a falling sclk edge, or before the first rising edge, and stays stable while sclk is high. The device samples it on the rising edge.
- R5: The data bytes follow the instruction without a break. Byte k is req_wdata[8k+7:8k], byte 0 is sent first, and the number of bytes sent follows the length code.
- R6: With lsb_first=1, the instruction is sent bit 0 first, and every data byte is sent bit 0 first. The fields themselves keep their order.
- R7: In a three-wire read, sdio_oe is 1 for the first 16 rising sclk edges and drops on the falling edge that ends the instruction phase. sdio_i is then captured on each later rising edge. Response bit j goes to byte j/8 of rd_data, at bit position j%8 when LSB-first and 7-j%8 otherwise. Bytes beyond the length are 0.
- R8: In a four-wire read (four_wire=1), sdio_oe stays 1 and the data is captured from sdo_i. sdio_i is ignored.
- R9: cs_n falls at least one system clock before the first rising sclk edge and rises after the final falling edge. Between transactions, cs_n stays high for at least 4*CLK_DIV system clocks, which is two sclk periods.
- R10: On start, table entry i (address 0x040+2*i, data 0xC3 XOR (i*0x11 mod 256)) is written as a single-byte write, in increasing i. Then 0x01 is written to UPDATE_ADDR, and done is pulsed.
- R11: busy is 1 from acceptance to the end of the operation. Any start or request that arrives while busy is ignored, and rd_data is left unchanged.
- R12: done is a one-cycle pulse at the end of every operation, with cs_n high and sclk low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the table load sequence |
| req_valid | input | 1 | Single host transaction request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_len | input | 2 | Length code (R3) |
| req_addr | input | 13 | Register address |
| req_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| four_wire | input | 1 | Use sdo_i for returned data |
| lsb_first | input | 1 | Reverse the bit order within each field |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Readback bytes |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| sdio_o | output | 1 | Data out to the shared pin |
| sdio_oe | output | 1 | Output enable of the shared pin |
| sdio_i | input | 1 | Data in from the shared pin |
| sdo_i | input | 1 | Separate data-out pin of the device |

## Verification
The bench builds the block with CLK_DIV=3, ROM_DEPTH=3 and UPDATE_ADDR=0x232. The odd divider makes the half-period and chip-select gap timing distinguishable from a divide-by-two. The short table lets the whole load sequence, including the final update write, be checked frame by frame within a few thousand cycles. A bench-side device model drives opposite values on the unused data pin, so a read that captures from the wrong pin shows up in rd_data.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int INSTR_W = 16;
    localparam int REG_AW  = 13;
    localparam int MAX_B   = 4;
    localparam int FRAME_W = INSTR_W + 8 * MAX_B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_GAP,
        ST_FINISH
    } cfg_state_t;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] v);
        for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
    endfunction
endpackage

// File: rtl/spi_cfg_clkgen.sv
module spi_cfg_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(DIV) + 1;

    logic [CW-1:0] cnt;
    logic          at_lim;

    assign at_lim = run && (cnt == CW'(DIV - 1));
    assign rise   = at_lim && !sclk;
    assign fall   = at_lim && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (at_lim) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: a stopped generator leaves the clock low
    assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
endmodule

// File: rtl/spi_cfg_rom.sv
module spi_cfg_rom #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [12:0]      addr,
    output logic [7:0]       data
);
    logic [12:0] addr_tab [DEPTH];
    logic [7:0]  data_tab [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        assign addr_tab[gi] = 13'h040 + 13'(2 * gi);
        assign data_tab[gi] = 8'hC3 ^ 8'((gi * 17) % 256);
    end

    always_comb begin
        addr = '0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == IDX_W'(i)) begin
                addr = addr_tab[i];
                data = data_tab[i];
            end
        end
    end
endmodule

// File: rtl/spi_cfg_master.sv
module spi_cfg_master
    import spi_cfg_pkg::*;
#(
    parameter int          CLK_DIV     = 4,
    parameter int          ROM_DEPTH   = 4,
    parameter logic [12:0] UPDATE_ADDR = 13'h0232
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        req_valid,
    input  logic        req_rd,
    input  logic [1:0]  req_len,
    input  logic [12:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic        four_wire,
    input  logic        lsb_first,
    output logic        busy,
    output logic        done,
    output logic [31:0] rd_data,
    output logic        sclk,
    output logic        cs_n,
    output logic        sdio_o,
    output logic        sdio_oe,
    input  logic        sdio_i,
    input  logic        sdo_i
);
    localparam int IDX_W   = $clog2(ROM_DEPTH + 1);
    localparam int GAP_CYC = 4 * CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    cfg_state_t state, nxt;

    logic [IDX_W-1:0]   idx;
    logic               rom_mode, last_x, is_rd, lsb_r, four_r, oe_r;
    logic [FRAME_W-1:0] txsh;
    logic [5:0]         bits_total, bitcnt;
    logic [GW-1:0]      gap_cnt;
    logic [31:0]        rd_r;
    logic               run, rise, fall, load_now, din;
    logic               ld_rd, ld_lsb;
    logic [1:0]         ld_len;
    logic [12:0]        ld_addr, rom_addr;
    logic [31:0]        ld_wdata;
    logic [7:0]         rom_data;
    logic [15:0]        ld_instr;
    logic [FRAME_W-1:0] ld_frame;
    logic [4:0]         rel;
    logic [2:0]         pos;

    spi_cfg_clkgen #(.DIV(CLK_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk), .rise(rise), .fall(fall));

    spi_cfg_rom #(.DEPTH(ROM_DEPTH), .IDX_W(IDX_W)) u_rom (
        .idx(idx), .addr(rom_addr), .data(rom_data));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
                       else if (req_valid) nxt = ST_XFER;
            ST_FETCH:  nxt = ST_XFER;
            ST_XFER:   if (fall && bitcnt == bits_total) nxt = ST_GAP;
            ST_GAP:    if (gap_cnt == GW'(GAP_CYC - 1))
                           nxt = (rom_mode && !last_x) ? ST_FETCH : ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n    = (state != ST_XFER);
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
        run     = (state == ST_XFER);
        sdio_o  = txsh[FRAME_W-1];
        sdio_oe = oe_r;
        rd_data = rd_r;
    end

    // frame source selection
    always_comb begin
        load_now = (state == ST_FETCH) || (state == ST_IDLE && !start && req_valid);
        ld_lsb   = (state == ST_IDLE) ? lsb_first : lsb_r;
        if (state == ST_FETCH) begin
            ld_rd    = 1'b0;
            ld_len   = 2'b00;
            ld_addr  = (idx == IDX_W'(ROM_DEPTH)) ? UPDATE_ADDR : rom_addr;
            ld_wdata = {24'h0, (idx == IDX_W'(ROM_DEPTH)) ? 8'h01 : rom_data};
        end else begin
            ld_rd    = req_rd;
            ld_len   = req_len;
            ld_addr  = req_addr;
            ld_wdata = req_wdata;
        end
        ld_instr = {ld_rd, ld_len, ld_addr};
        ld_frame[FRAME_W-1 -: 16] = ld_lsb ? rev16(ld_instr) : ld_instr;
        for (int b = 0; b < MAX_B; b++)
            ld_frame[31-8*b -: 8] = ld_lsb ? rev8(ld_wdata[8*b +: 8]) : ld_wdata[8*b +: 8];
        rel = 5'(bitcnt - 6'd16);
        pos = lsb_r ? rel[2:0] : (3'd7 - rel[2:0]);
        din = four_r ? sdo_i : sdio_i;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0; rom_mode <= 1'b0; last_x <= 1'b0; is_rd <= 1'b0;
            lsb_r <= 1'b0; four_r <= 1'b0; oe_r <= 1'b1; txsh <= '0;
            bits_total <= '0; bitcnt <= '0; gap_cnt <= '0; rd_r <= '0;
        end else begin
            if (state == ST_IDLE && (start || req_valid)) begin
                lsb_r    <= lsb_first;
                four_r   <= four_wire;
                rom_mode <= start;
                idx      <= '0;
                last_x   <= 1'b0;
                if (!start && req_rd) rd_r <= '0;
            end
            if (state == ST_FETCH) begin
                last_x <= (idx == IDX_W'(ROM_DEPTH));
                idx    <= idx + 1'b1;
            end
            if (load_now) begin
                txsh       <= ld_frame;
                is_rd      <= ld_rd;
                bits_total <= 6'd24 + {1'b0, ld_len, 3'b000};
                bitcnt     <= '0;
                gap_cnt    <= '0;
                oe_r       <= 1'b1;
            end
            if (state == ST_XFER) begin
                if (rise) begin
                    if (is_rd && bitcnt >= 6'd16) rd_r[{rel[4:3], pos}] <= din;
                    bitcnt <= bitcnt + 1'b1;
                end
                if (fall && bitcnt != bits_total) begin
                    txsh <= {txsh[FRAME_W-2:0], 1'b0};
                    if (is_rd && !four_r && bitcnt == 6'd16) oe_r <= 1'b0;
                end
            end
            if (state == ST_GAP) begin
                oe_r    <= 1'b1;
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // checker state: cycles spent with chip select high
    logic [GW:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hi_run <= (GW+1)'(GAP_CYC + 1);
        else if (!cs_n)                          hi_run <= '0;
        else if (hi_run < (GW+1)'(GAP_CYC + 1))  hi_run <= hi_run + 1'b1;
    end

    assert_sclk_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    assert_data_stable_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdio_o));
    assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdio_o));
    assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> (!cs_n && !sclk && is_rd));
    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_run >= (GW+1)'(GAP_CYC)));
    assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sclk));
endmodule

// File: tb/sim_spi_cfg_master.sv
module sim_spi_cfg_master;
    localparam int DIV = 3;
    localparam int DEPTH = 3;
    localparam logic [12:0] UPD = 13'h0232;
    localparam real TCLK = 20.0;

    logic clk = 0, rst_n = 0;
    logic start = 0, req_valid = 0, req_rd = 0, four_wire = 0, lsb_first = 0;
    logic [1:0] req_len = 0;
    logic [12:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic busy, done, sclk, cs_n, sdio_o, sdio_oe;
    logic sdio_i = 0, sdo_i = 0;
    logic [31:0] rd_data;

    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    spi_cfg_master #(.CLK_DIV(DIV), .ROM_DEPTH(DEPTH), .UPDATE_ADDR(UPD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid), .req_rd(req_rd),
        .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
        .four_wire(four_wire), .lsb_first(lsb_first), .busy(busy), .done(done),
        .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sdio_i(sdio_i), .sdo_i(sdo_i));

    // device model and monitor
    logic [47:0] capv;
    int ncap, nrise, first_low, oe_low;
    realtime t_csfall, t_csrise, t_r1, t_r2, min_gap;
    int ntx;
    logic [47:0] txlog [8];
    int txn [8];
    logic [31:0] resp;
    logic resp_lsb, resp_four;

    always @(negedge cs_n) begin
        if (ntx > 0 && (($realtime - t_csrise) < min_gap)) min_gap = $realtime - t_csrise;
        t_csfall = $realtime;
        capv = '0; ncap = 0; nrise = 0; first_low = -1; oe_low = 0;
    end
    always @(posedge sclk) if (!cs_n) begin
        if (sdio_oe) begin capv = {capv[46:0], sdio_o}; ncap++; end
        else begin if (first_low < 0) first_low = nrise; oe_low++; end
        if (nrise == 0) t_r1 = $realtime;
        if (nrise == 1) t_r2 = $realtime;
        nrise++;
    end
    always @(negedge sclk) if (!cs_n && nrise >= 16 && nrise < 48) begin
        int j;
        logic b;
        j = nrise - 16;
        b = resp[8*(j/8) + (resp_lsb ? j%8 : 7 - j%8)];
        if (resp_four) begin sdo_i = b; sdio_i = ~b; end
        else begin sdio_i = b; sdo_i = ~b; end
    end
    always @(posedge cs_n) if (nrise > 0) begin
        t_csrise = $realtime;
        if (ntx < 8) begin txlog[ntx] = capv; txn[ntx] = ncap; end
        ntx++;
    end

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_frame(input logic rd, input logic [1:0] len,
        input logic [12:0] addr, input logic [31:0] wd, input logic lsb, output int n);
        logic [15:0] ins;
        logic [47:0] e;
        ins = {rd, len, addr};
        e = '0;
        for (int k = 0; k < 16; k++) e = {e[46:0], lsb ? ins[k] : ins[15-k]};
        n = 16;
        if (!rd) begin
            for (int b = 0; b <= int'(len); b++)
                for (int k = 0; k < 8; k++) e = {e[46:0], lsb ? wd[8*b+k] : wd[8*b+7-k]};
            n = 16 + 8 * (int'(len) + 1);
        end
        return e;
    endfunction

    task automatic wait_done(input string req);
        int c;
        c = 0;
        while (done !== 1'b1 && c < 20000) begin @(negedge clk); c++; end
        chk(done === 1'b1, {req, " done seen"}, 48'(done), 48'd1);
        @(negedge clk);
        chk(done === 1'b0, "R12 done one cycle wide", 48'(done), 48'd0);
    endtask

    task automatic issue(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                         input logic [31:0] wd, input logic four, input logic lsb);
        @(negedge clk);
        req_valid = 1; req_rd = rd; req_len = len; req_addr = addr; req_wdata = wd;
        four_wire = four; lsb_first = lsb; ntx = 0; min_gap = 1.0e9;
        @(negedge clk);
        req_valid = 0;
        chk(busy === 1'b1, "R11 busy after accept", 48'(busy), 48'd1);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1, "R1 cs_n", 48'(cs_n), 48'd1);
        chk(sclk === 1'b0, "R1 sclk", 48'(sclk), 48'd0);
        chk(busy === 1'b0, "R1 busy", 48'(busy), 48'd0);
        chk(done === 1'b0, "R1 done", 48'(done), 48'd0);
        chk(sdio_oe === 1'b1, "R1 sdio_oe", 48'(sdio_oe), 48'd1);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_write(input logic [1:0] len, input logic [12:0] addr,
                           input logic [31:0] wd, input logic lsb, input string req);
        logic [47:0] e;
        int n;
        issue(0, len, addr, wd, 0, lsb);
        wait_done(req);
        e = exp_frame(0, len, addr, wd, lsb, n);
        chk(ntx == 1, {req, " one transaction"}, 48'(ntx), 48'd1);
        chk(txn[0] == n, {req, " R5 bit count"}, 48'(txn[0]), 48'(n));
        chk(txlog[0] == e, {req, " R3 frame bits"}, txlog[0], e);
        chk((t_r2 - t_r1) == 2.0 * DIV * TCLK, "R2 sclk period", 48'(int'(t_r2 - t_r1)), 48'(int'(2.0 * DIV * TCLK)));
        chk((t_r1 - t_csfall) >= TCLK, "R9 cs setup", 48'(int'(t_r1 - t_csfall)), 48'(int'(TCLK)));
    endtask

    task automatic t_read(input logic [1:0] len, input logic [12:0] addr, input logic [31:0] rsp,
                          input logic four, input logic lsb, input string req);
        logic [47:0] e;
        logic [31:0] expd;
        int n, nb;
        resp = rsp; resp_lsb = lsb; resp_four = four;
        nb = int'(len) + 1;
        expd = '0;
        for (int b = 0; b < nb; b++) expd[8*b +: 8] = rsp[8*b +: 8];
        issue(1, len, addr, 32'h0, four, lsb);
        wait_done(req);
        e = exp_frame(1, len, addr, 32'h0, lsb, n);
        chk(((four ? (txlog[0] >> (8*nb)) : txlog[0]) & 48'hFFFF) == e, {req, " R3 read instruction"}, txlog[0], e);
        chk(rd_data == expd, {req, " rd_data"}, 48'(rd_data), 48'(expd));
        if (four) begin
            chk(oe_low == 0, "R8 oe held in four-wire", 48'(oe_low), 48'd0);
        end else begin
            chk(first_low == 16, "R7 oe release edge", 48'(first_low), 48'd16);
            chk(oe_low == 8 * nb, "R7 oe low count", 48'(oe_low), 48'(8 * nb));
        end
    endtask

    task automatic t_rom();
        logic [31:0] keep;
        logic [47:0] e;
        int n;
        keep = rd_data;
        @(negedge clk);
        start = 1; lsb_first = 0; four_wire = 0; ntx = 0; min_gap = 1.0e9;
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        req_valid = 1; req_rd = 1; req_len = 2'b11; start = 1;
        @(negedge clk);
        req_valid = 0; start = 0;
        wait_done("R10");
        chk(ntx == DEPTH + 1, "R11 ignored request adds no transaction", 48'(ntx), 48'(DEPTH + 1));
        for (int i = 0; i < DEPTH; i++) begin
            e = exp_frame(0, 2'b00, 13'h040 + 13'(2 * i), {24'h0, 8'hC3 ^ 8'((i * 17) % 256)}, 0, n);
            chk(txlog[i] == e && txn[i] == n, "R10 table entry frame", txlog[i], e);
        end
        e = exp_frame(0, 2'b00, UPD, 32'h01, 0, n);
        chk(txlog[DEPTH] == e, "R10 update write", txlog[DEPTH], e);
        chk(min_gap >= 4.0 * DIV * TCLK, "R9 cs high gap", 48'(int'(min_gap)), 48'(int'(4.0 * DIV * TCLK)));
        chk(rd_data == keep, "R11 rd_data untouched by ignored read", 48'(rd_data), 48'(keep));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ntx = 0; min_gap = 1.0e9; resp = 0; resp_lsb = 0; resp_four = 0;
        t_reset();
        t_write(2'b00, 13'h00A5, 32'h0000_003C, 0, "R5 single byte");
        t_write(2'b10, 13'h01F0, 32'h00AB_CDEF, 0, "R5 three bytes");
        t_write(2'b11, 13'h0123, 32'h89AB_CDEF, 1, "R6 lsb-first stream");
        t_read(2'b00, 13'h0005, 32'hDEAD_BE96, 0, 0, "R7 three-wire one byte");
        t_read(2'b01, 13'h1ABC, 32'h1234_A55A, 0, 1, "R7 three-wire lsb two bytes");
        t_read(2'b11, 13'h0777, 32'hC0FF_EE42, 1, 0, "R8 four-wire stream");
        t_rom();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule